// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is a single-channel memory-to-memory copy engine. It follows a linked list of descriptors held in memory. Each descriptor occupies four 32-bit words on a 16-byte boundary, in this order: byte count, source address, destination address, next-descriptor address. Software programs a 32-bit register port. When software writes a descriptor address into the next-pointer register while the engine is enabled, the engine fetches that descriptor and copies the data word by word. It then writes the count word back to memory with the ownership flag cleared and moves on to the next descriptor. A next pointer of zero ends the chain.

The memory side is a simple word-wide master. A request holds its address, direction and write data until the memory acknowledges it. Read data is taken in the cycle of the acknowledge. The `busy` output, which software also sees as the active bit of the control register, stays high from the start of a chain until the engine is idle again.

Top module: `cdma_engine`

## Requirements
- R1: After reset `busy` is low, `mem_req` is low, and every register reads zero. No memory request is issued while `busy` is low.
- R2: A write to offset 0x30 while control bit 12 (enable) is set and the engine is idle starts a chain at the written address. `busy` is high in the cycle after the write. The descriptor is read as four words at address +0, +4, +8 and +12: count, source, destination, next.
- R3: The transfer length in bytes is count bits 29:0. Bit 31 is the ownership flag and bit 30 is the left-over flag. The engine copies ceil(length/4) words from source to destination, in ascending order.
- R4: After its last word, a descriptor gets its count word rewritten in memory with bit 31 cleared. All other bits, bit 30 included, are kept.
- R5: After completing a descriptor, the engine follows its next pointer. A next pointer of zero ends the chain, and `busy` falls.
- R6: A descriptor whose length is zero causes no data access and no write-back, and the chain continues at its next pointer. An all-zero descriptor therefore ends the chain.
- R7: The registers at 0x00, 0x10, 0x20 and 0x30 hold the fields of the most recently fetched descriptor. The register at 0x70 holds that descriptor's address.
- R8: A write to 0x30 while enable is clear only stores the address. No transfer starts.
- R9: With control bit 9 (non-chained) set, the engine stops after one descriptor, whatever its next pointer holds.
- R10: Clearing enable during a copy lets the word being moved finish its write, then the engine stops without write-back. `busy` stays high until the engine has stopped.
- R11: While idle, writes to 0x00, 0x10, 0x20, 0x30 and 0x70 store the value written, so writing zero clears chain state. While busy, these writes are ignored.
- R12: A control write with bits 12 and 13 both set, while idle, starts a chain at the address held in 0x30. Bit 13 reads 1 only while a descriptor is being fetched.
- R13: Control bits 2:0 (destination burst code), 8:6 (source burst code), 9 and 12 are stored and read back. Bit 14 reads the active state and ignores writes.
- R14: A memory request keeps `mem_req`, `mem_addr` and `mem_we` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered, for the offset of the previous cycle |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| busy | output | 1 | Engine active |

## Verification
Register reads are registered. The bench therefore presents an offset before one rising edge and samples `reg_rdata` shortly after that edge. A start shows up on `busy` one edge after the write is captured, and it is checked at that point. Memory latency is randomised, so chain results are not tied to a cycle. The bench waits for `busy` to fall, with a bound, and then compares the whole memory image against a model of the descriptor walk. For the disable-during-copy case, the bench counts destination writes already seen when the disable write lands. It allows at most two more: one for a word whose write is acknowledged on that same edge, and one for the word then in flight.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 30;
  localparam int WC_W   = LEN_W - 1;

  localparam logic [7:0] OFS_CNT = 8'h00;
  localparam logic [7:0] OFS_SRC = 8'h10;
  localparam logic [7:0] OFS_DST = 8'h20;
  localparam logic [7:0] OFS_NXT = 8'h30;
  localparam logic [7:0] OFS_CTL = 8'h40;
  localparam logic [7:0] OFS_CUR = 8'h70;

  localparam int B_NOCHAIN = 9;
  localparam int B_EN      = 12;
  localparam int B_FETCH   = 13;
  localparam int B_ACT     = 14;
  localparam int B_OWN     = 31;

  localparam logic [WORD_W-1:0] CTL_KEEP = 32'h0000_13C7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_RD, ST_WR, ST_WB
  } walk_st_t;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              fetching,
  input  logic [WORD_W-1:0] cnt_q,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [ADDR_W-1:0] nxt_q,
  input  logic [ADDR_W-1:0] cur_q,
  output logic              ctrl_en,
  output logic              ctrl_nochain,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [WORD_W-1:0] ctl_q;
  logic              hit_nxt, hit_ctl;

  assign hit_nxt      = reg_we && (reg_addr == REG_AW'(OFS_NXT));
  assign hit_ctl      = reg_we && (reg_addr == REG_AW'(OFS_CTL));
  assign ctrl_en      = ctl_q[B_EN];
  assign ctrl_nochain = ctl_q[B_NOCHAIN];

  always_comb begin
    start      = 1'b0;
    start_addr = nxt_q;
    if (!busy) begin
      if (hit_nxt && ctrl_en) begin
        start      = 1'b1;
        start_addr = ADDR_W'(reg_wdata);
      end else if (hit_ctl && reg_wdata[B_EN] && reg_wdata[B_FETCH]) begin
        start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (hit_ctl) ctl_q <= reg_wdata & CTL_KEEP;
      case (reg_addr)
        REG_AW'(OFS_CNT): reg_rdata <= cnt_q;
        REG_AW'(OFS_SRC): reg_rdata <= WORD_W'(src_q);
        REG_AW'(OFS_DST): reg_rdata <= WORD_W'(dst_q);
        REG_AW'(OFS_NXT): reg_rdata <= WORD_W'(nxt_q);
        REG_AW'(OFS_CUR): reg_rdata <= WORD_W'(cur_q);
        REG_AW'(OFS_CTL): begin
          reg_rdata         <= ctl_q;
          reg_rdata[B_ACT]   <= busy;
          reg_rdata[B_FETCH] <= fetching;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cdma_walker.sv
module cdma_walker
  import cdma_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              ctrl_en,
  input  logic              ctrl_nochain,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              fetching,
  output logic [WORD_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] nxt_q,
  output logic [ADDR_W-1:0] cur_q
);
  walk_st_t          st_q;
  logic [1:0]        idx_q;
  logic [WC_W-1:0]   wofs_q, left_q, words;
  logic [WORD_W-1:0] buf_q;
  logic [LEN_W:0]    len_rnd;
  logic              last_desc;

  assign len_rnd   = {1'b0, cnt_q[LEN_W-1:0]} + (LEN_W+1)'(3);
  assign words     = len_rnd[LEN_W:2];
  assign last_desc = (nxt_q == '0) || ctrl_nochain;
  assign busy      = (st_q != ST_IDLE);
  assign fetching  = (st_q == ST_FETCH);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = buf_q;
    case (st_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'({idx_q, 2'b00});
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q + ADDR_W'({wofs_q, 2'b00});
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q + ADDR_W'({wofs_q, 2'b00});
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = cnt_q;
        mem_wdata[B_OWN] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      wofs_q <= '0;
      left_q <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      cur_q  <= '0;
    end else begin
      if (reg_we && !busy) begin
        case (reg_addr)
          REG_AW'(OFS_CNT): cnt_q <= reg_wdata;
          REG_AW'(OFS_SRC): src_q <= ADDR_W'(reg_wdata);
          REG_AW'(OFS_DST): dst_q <= ADDR_W'(reg_wdata);
          REG_AW'(OFS_NXT): nxt_q <= ADDR_W'(reg_wdata);
          REG_AW'(OFS_CUR): cur_q <= ADDR_W'(reg_wdata);
          default: ;
        endcase
      end
      case (st_q)
        ST_IDLE: if (start) begin
          cur_q <= start_addr;
          idx_q <= '0;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          case (idx_q)
            2'd0: cnt_q <= mem_rdata;
            2'd1: src_q <= ADDR_W'(mem_rdata);
            2'd2: dst_q <= ADDR_W'(mem_rdata);
            default: nxt_q <= ADDR_W'(mem_rdata);
          endcase
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) st_q <= ctrl_en ? ST_DECIDE : ST_IDLE;
        end
        ST_DECIDE: begin
          wofs_q <= '0;
          left_q <= words;
          if (words != '0) begin
            st_q <= ST_RD;
          end else if (last_desc) begin
            st_q <= ST_IDLE;
          end else begin
            cur_q <= nxt_q;
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        ST_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st_q  <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          wofs_q <= wofs_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (!ctrl_en)                 st_q <= ST_IDLE;
          else if (left_q == WC_W'(1))  st_q <= ST_WB;
          else                          st_q <= ST_RD;
        end
        ST_WB: if (mem_ack) begin
          if (last_desc) begin
            st_q <= ST_IDLE;
          end else begin
            cur_q <= nxt_q;
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              busy
);
  logic              ctrl_en, ctrl_nochain, start, fetching;
  logic [ADDR_W-1:0] start_addr, src_q, dst_q, nxt_q, cur_q;
  logic [WORD_W-1:0] cnt_q;

  cdma_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .fetching(fetching),
    .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q),
    .cur_q(cur_q), .ctrl_en(ctrl_en), .ctrl_nochain(ctrl_nochain),
    .start(start), .start_addr(start_addr), .reg_rdata(reg_rdata)
  );

  cdma_walker #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_en(ctrl_en), .ctrl_nochain(ctrl_nochain),
    .start(start), .start_addr(start_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
    .fetching(fetching), .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
    .nxt_q(nxt_q), .cur_q(cur_q)
  );
endmodule

// File: rtl/cdma_engine_chk.sv
module cdma_engine_chk
  import cdma_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              busy,
  input logic              ctrl_en,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R1

  AST_START_NEXT: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == REG_AW'(OFS_NXT) && ctrl_en && !busy) |=> busy); // R2

  AST_NO_START_DIS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctrl_en && !(reg_we && reg_addr == REG_AW'(OFS_CTL))) |=> !busy); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R14
endmodule

bind cdma_engine cdma_engine_chk #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .busy(busy),
  .ctrl_en(ctrl_en), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr)
);

// File: tb/cdma_engine_tb.sv
module cdma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 1024;
  localparam logic [31:0] EN = 32'h1000, FETCH = 32'h2000, NOCH = 32'h0200;
  localparam logic [31:0] OWN = 32'h8000_0000, LEFT = 32'h4000_0000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, busy;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [31:0] mem [MEMW];
  logic [31:0] expm [MEMW];
  int n_acc = 0, n_dstw = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdma_engine dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy)
  );

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      n_acc = n_acc + 1;
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        if (mem_addr >= 32'h800 && mem_addr < 32'hC00) n_dstw = n_dstw + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, req, 32'(n), 32'd0);
  endtask

  task automatic fill();
    for (int i = 0; i < MEMW; i++) mem[i] = $urandom;
    for (int i = 16; i < 64; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, s, d, n);
    mem[a/4] = c; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = n;
  endtask

  task automatic model(input int start, input bit noch);
    int a = start;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] c = expm[a/4];
      int len = int'(c[29:0]);
      int w = (len + 3) / 4;
      for (int j = 0; j < w; j++) expm[expm[a/4+2]/4 + j] = expm[expm[a/4+1]/4 + j];
      if (len != 0) expm[a/4] = c & ~OWN;
      if (expm[a/4+3] == 0 || noch) break;
      a = int'(expm[a/4+3]);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0; int first = -1;
    for (int i = 0; i < MEMW; i++) if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, mem[first], expm[first]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, seen;
    void'($urandom(32'd77));
    fill();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(!busy && !mem_req, "R1 idle", {30'd0, busy, mem_req}, 0);
    foreach (dut_i.u_regs.ctl_q[i]) ;
    rd(8'h00, v); chk(v == 0, "R1 cnt", v, 0);
    rd(8'h30, v); chk(v == 0, "R1 nxt", v, 0);
    rd(8'h40, v); chk(v == 0, "R1 ctl", v, 0);

    // R13: control fields stored, active bit read-only
    wr(8'h40, 32'h0000_4000 | EN | 32'h4 | (32'h3 << 6));
    rd(8'h40, v); chk(v == (EN | 32'h4 | 32'hC0), "R13 ctl", v, EN | 32'hC4);

    // R11: idle writes stored, zero clears
    wr(8'h10, 32'h1234); rd(8'h10, v); chk(v == 32'h1234, "R11 store", v, 32'h1234);
    wr(8'h10, 32'h0);    rd(8'h10, v); chk(v == 0, "R11 clear", v, 0);

    // R2 R3 R4 R7: single descriptor, odd length with left flag
    fill();
    put_desc(32'h100, OWN | LEFT | 32'd10, 32'h400, 32'h800, 0);
    expm = mem; model(32'h100, 0);
    wr(8'h30, 32'h100);
    chk(busy, "R2 start", {31'd0, busy}, 1);
    wait_idle("R2 finish");
    cmp_mem("R3 copy");
    chk(mem[32'h40] == (LEFT | 32'd10), "R4 writeback", mem[32'h40], LEFT | 32'd10);
    rd(8'h00, v); chk(v == (OWN | LEFT | 32'd10), "R7 cnt", v, OWN | LEFT | 32'd10);
    rd(8'h20, v); chk(v == 32'h800, "R7 dst", v, 32'h800);
    rd(8'h70, v); chk(v == 32'h100, "R7 cur", v, 32'h100);

    // R5 R6: chain with zero-length entry and separator
    fill();
    put_desc(32'h40, OWN | 32'd8, 32'h400, 32'h800, 32'h50);
    put_desc(32'h50, OWN,         32'h410, 32'h810, 32'h60);
    put_desc(32'h60, OWN | 32'd5, 32'h420, 32'h820, 32'h70);
    put_desc(32'h70, 0, 0, 0, 0);
    expm = mem; model(32'h40, 0);
    base = n_acc;
    wr(8'h30, 32'h40);
    wait_idle("R5 finish");
    cmp_mem("R5 chain");
    chk(mem[32'h50/4] == OWN, "R6 no writeback", mem[32'h50/4], OWN);
    chk(n_acc - base == 26, "R6 access count", 32'(n_acc - base), 26);
    rd(8'h70, v); chk(v == 32'h70, "R5 last cur", v, 32'h70);

    // R8: disabled next-pointer write only stores
    wr(8'h40, 32'h0);
    fill();
    put_desc(32'h100, OWN | 32'd8, 32'h400, 32'h800, 0);
    expm = mem;
    wr(8'h30, 32'h100);
    repeat (5) @(negedge clk);
    chk(!busy, "R8 no start", {31'd0, busy}, 0);
    rd(8'h30, v); chk(v == 32'h100, "R8 stored", v, 32'h100);
    cmp_mem("R8 memory untouched");

    // R12: start through control fetch bit
    model(32'h100, 0);
    wr(8'h40, EN | FETCH);
    chk(busy, "R12 start", {31'd0, busy}, 1);
    wait_idle("R12 finish");
    cmp_mem("R12 copy");
    rd(8'h40, v); chk(v == EN, "R12 ctl readback", v, EN);

    // R9: non-chained mode
    wr(8'h40, EN | NOCH);
    fill();
    put_desc(32'h40, OWN | 32'd4, 32'h400, 32'h800, 32'h50);
    put_desc(32'h50, OWN | 32'd4, 32'h410, 32'h810, 0);
    expm = mem; model(32'h40, 1);
    wr(8'h30, 32'h40);
    wait_idle("R9 finish");
    cmp_mem("R9 single");
    rd(8'h30, v); chk(v == 32'h50, "R9 nxt mirror", v, 32'h50);

    // R11: writes ignored while busy
    wr(8'h40, EN);
    fill();
    put_desc(32'h40, OWN | 32'd128, 32'h400, 32'h800, 0);
    wr(8'h30, 32'h40);
    repeat (10) @(negedge clk);
    wr(8'h10, 32'hDEAD);
    wait_idle("R11 finish");
    rd(8'h10, v); chk(v == 32'h400, "R11 ignored busy", v, 32'h400);

    // R10: disable mid-copy
    fill();
    put_desc(32'h40, OWN | 32'd256, 32'h400, 32'h800, 0);
    base = n_dstw;
    wr(8'h30, 32'h40);
    while (n_dstw - base < 5) @(negedge clk);
    seen = n_dstw - base;
    chk(busy, "R10 busy while copying", {31'd0, busy}, 1);
    wr(8'h40, 32'h0);
    wait_idle("R10 stop");
    chk((n_dstw - base) >= seen && (n_dstw - base) <= seen + 2, "R10 word count",
        32'(n_dstw - base), 32'(seen));
    chk(mem[32'h10] == (OWN | 32'd256), "R10 no writeback", mem[32'h10], OWN | 32'd256);

    // R3 R5: random chains
    wr(8'h40, EN);
    for (int it = 0; it < 20; it++) begin
      int n = 1 + int'($urandom % 4);
      fill();
      for (int i = 0; i < n; i++)
        put_desc(32'h40 + i*16, OWN | (($urandom % 2) ? LEFT : 0) | 32'($urandom % 33),
                 32'h400 + i*32'h40, 32'h800 + i*32'h40,
                 (i == n-1) ? 0 : 32'h40 + (i+1)*16);
      expm = mem; model(32'h40, 0);
      wr(8'h30, 32'h40);
      wait_idle("R5 random finish");
      cmp_mem("R3 random chain");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule